// File: doc/BRIEF.md
# Synchronous Character Transmitter with Idle Fill

This block turns bytes written by a host into one unbroken serial bit stream for a synchronous link. It has a single holding register for the next character and a shift register for the character on the line. The line carries no framing: each character is its bits back to back, least significant bit first, with one bit per clock.

A stream starts with a lead-in of fill characters. Once it is running, the stream never pauses. If the host has not refilled the holding register by the time a character ends, the block sends the programmed fill pattern instead, and an empty flag tells the host that it has fallen behind. The fill pattern is either one programmed byte repeated, or a fixed pair of two programmed bytes.

The host side is clocked on the rising edge of `clk` and the serial side on the falling edge. The line therefore changes only on falling edges, and a write made at a rising edge is seen by the serializer half a cycle later.

Top module: `sync_tx_filler`

## Requirements
- R1: While reset is applied and after it is released, `txd` is 1, `buf_ready` is 1 and `tx_empty` is 1.
- R2: While `tx_en` is low, `txd` stays at 1 (mark) and no character is started, even when the holding register is loaded.
- R3: `txd` changes only at falling edges of `clk`, one bit per clock period.
- R4: The first falling edge that sees `tx_en` high while the block is idle starts the stream with the fill pattern: first character 1 (`sync1`), then the second fill character (`sync2`) when `two_sync` is 1. This happens even if the holding register already has a character.
- R5: Characters are CHAR_W bits (8 by default), sent least significant bit first with no start, stop or parity bits. The next character follows the previous one with no gap.
- R6: When a character ends and the holding register is empty, fill is sent. With `two_sync` = 0 the fill is `sync1`, repeated.
- R7: With `two_sync` = 1 the fill is `sync1` followed by `sync2`. A pair that has started always finishes before data is sent again.
- R8: A byte written at a rising edge of `clk` is seen at the next falling edge. It is sent at the first character boundary that is not the start of the stream and not in the middle of a fill pair.
- R9: `tx_empty` is 1 exactly when the holding register is empty and the character on the line is not a data character. It falls at the write, and rises again when the last bit of the data character has been sent and fill takes over.
- R10: `buf_ready` falls at the rising edge that accepts a write. It rises at the falling edge where that character moves into the shift register.
- R11: A write while `buf_ready` is 0 is dropped. The byte already held is the one that is sent.
- R12: When `tx_en` drops in the middle of a character, that character is completed. `txd` then returns to 1 at the next character boundary.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock; host side on rising edge, line on falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_en | input | 1 | Transmit enable |
| two_sync | input | 1 | 1: fill pattern is a pair of bytes; 0: a single byte |
| sync1 | input | CHAR_W | First fill byte |
| sync2 | input | CHAR_W | Second fill byte (used only when two_sync is 1) |
| wr_stb | input | 1 | Host write strobe, one cycle |
| wr_data | input | CHAR_W | Byte to transmit |
| txd | output | 1 | Serial data out |
| buf_ready | output | 1 | Holding register can take a byte |
| tx_empty | output | 1 | Holding register empty and fill (or idle) on the line |

## Verification
The bench sweeps the write slot over every bit position of the lead-in and of the first fill characters, in both fill modes, and also writes before the stream starts. A design that let data cut into the lead-in or split a fill pair would put the data byte one character early. A design that read the write one clock late would miss a boundary and send the byte one fill period later. Two more cases are covered. A second write while the register is full must not replace the held byte; a design that got this wrong would send the later byte or send both. A disable in the middle of a character must not cut that character short or leave extra bits on the line.

// File: rtl/sync_tx_pkg.sv
package sync_tx_pkg;

  // Kind of character presented to the shift register at a boundary.
  typedef enum logic [1:0] {
    KIND_SYNC1 = 2'd0,
    KIND_SYNC2 = 2'd1,
    KIND_DATA  = 2'd2
  } char_kind_e;

endpackage

// File: rtl/stx_rst_sync.sv
module stx_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] stage_q;

  // Assert at once, release after two rising edges.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 2'b00;
    end else begin
      stage_q <= {stage_q[0], 1'b1};
    end
  end

  assign rst_sync_n = stage_q[1];

endmodule

// File: rtl/stx_hold_buf.sv
module stx_hold_buf #(
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic [CHAR_W-1:0] wr_data,
  input  logic              take_tog,   // toggled by the line side on each data load
  output logic              full,
  output logic [CHAR_W-1:0] hold_data
);

  logic              put_tog_q, put_tog_d;
  logic [CHAR_W-1:0] data_q, data_d;
  logic              accept;

  // Occupied while the two toggles disagree.
  assign full   = put_tog_q ^ take_tog;
  assign accept = wr_stb & ~full;

  always_comb begin
    put_tog_d = put_tog_q;
    data_d    = data_q;
    if (accept) begin
      put_tog_d = ~put_tog_q;
      data_d    = wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      put_tog_q <= 1'b0;
      data_q    <= '0;
    end else begin
      put_tog_q <= put_tog_d;
      data_q    <= data_d;
    end
  end

  assign hold_data = data_q;

  // R11: a write that meets a full register leaves the held byte alone.
  a_r11_full_write_dropped : assert property (
    @(posedge clk) disable iff (!rst_n)
    (wr_stb && full) |=> $stable(data_q)
  );

  // R10: occupancy only ever begins through a host write.
  a_r10_fill_from_write : assert property (
    @(posedge clk) disable iff (!rst_n)
    $rose(full) |-> $past(wr_stb)
  );

endmodule

// File: rtl/stx_sequencer.sv
module stx_sequencer
  import sync_tx_pkg::*;
#(
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_en,
  input  logic              two_sync,
  input  logic [CHAR_W-1:0] sync1,
  input  logic [CHAR_W-1:0] sync2,
  input  logic              full,
  input  logic [CHAR_W-1:0] hold_data,
  input  logic              char_last,
  output logic              load,
  output logic [CHAR_W-1:0] load_word,
  output logic              run_next,
  output logic              take_tog,
  output logic              tx_empty
);

  logic       active_q, active_d;
  logic       pair_q, pair_d;
  logic       take_q, take_d;
  char_kind_e kind_q, kind_d;
  char_kind_e kind_ld;
  logic       boundary;

  assign boundary = ~active_q | char_last;

  // Boundary arbiter: lead-in, then pair completion, then data, else fill.
  always_comb begin
    load     = 1'b0;
    kind_ld  = KIND_SYNC1;
    active_d = active_q;
    pair_d   = pair_q;
    take_d   = take_q;
    kind_d   = kind_q;
    if (boundary) begin
      if (!tx_en) begin
        active_d = 1'b0;
        pair_d   = 1'b0;
        kind_d   = KIND_SYNC1;
      end else begin
        load     = 1'b1;
        active_d = 1'b1;
        if (active_q && pair_q) begin
          kind_ld = KIND_SYNC2;
          pair_d  = 1'b0;
        end else if (active_q && full) begin
          kind_ld = KIND_DATA;
          take_d  = ~take_q;
        end else begin
          kind_ld = KIND_SYNC1;
          pair_d  = two_sync;
        end
        kind_d = kind_ld;
      end
    end
  end

  always_comb begin
    unique case (kind_ld)
      KIND_SYNC2: load_word = sync2;
      KIND_DATA:  load_word = hold_data;
      default:    load_word = sync1;
    endcase
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      pair_q   <= 1'b0;
      take_q   <= 1'b0;
      kind_q   <= KIND_SYNC1;
    end else begin
      active_q <= active_d;
      pair_q   <= pair_d;
      take_q   <= take_d;
      kind_q   <= kind_d;
    end
  end

  assign run_next = active_d;
  assign take_tog = take_q;
  assign tx_empty = ~full & (kind_q != KIND_DATA);

endmodule

// File: rtl/stx_shifter.sv
module stx_shifter #(
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [CHAR_W-1:0] load_word,
  input  logic              run_next,
  output logic              txd,
  output logic              char_last
);

  localparam int CNT_W = (CHAR_W > 1) ? $clog2(CHAR_W) : 1;
  localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(CHAR_W - 1);

  logic [CHAR_W-1:0] sh_q, sh_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              txd_q, txd_d;

  assign char_last = (cnt_q == '0);

  always_comb begin
    sh_d  = sh_q;
    cnt_d = cnt_q;
    txd_d = txd_q;
    if (load) begin
      txd_d = load_word[0];
      sh_d  = load_word >> 1;
      cnt_d = CNT_TOP;
    end else if (!run_next) begin
      txd_d = 1'b1;
      sh_d  = '0;
      cnt_d = '0;
    end else begin
      txd_d = sh_q[0];
      sh_d  = sh_q >> 1;
      cnt_d = cnt_q - CNT_W'(1);
    end
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      cnt_q <= '0;
      txd_q <= 1'b1;
    end else begin
      sh_q  <= sh_d;
      cnt_q <= cnt_d;
      txd_q <= txd_d;
    end
  end

  assign txd = txd_q;

  // R5: a new character is only accepted once the previous one is spent.
  a_r5_load_on_boundary : assert property (
    @(negedge clk) disable iff (!rst_n)
    load |-> (cnt_q == '0)
  );

  // R12: stopping the stream leaves the line at mark.
  a_r12_idle_mark : assert property (
    @(negedge clk) disable iff (!rst_n)
    !run_next |=> txd_q
  );

endmodule

// File: rtl/sync_tx_filler.sv
module sync_tx_filler #(
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_en,
  input  logic              two_sync,
  input  logic [CHAR_W-1:0] sync1,
  input  logic [CHAR_W-1:0] sync2,
  input  logic              wr_stb,
  input  logic [CHAR_W-1:0] wr_data,
  output logic              txd,
  output logic              buf_ready,
  output logic              tx_empty
);

  logic              rst_sync_n;
  logic              full;
  logic [CHAR_W-1:0] hold_data;
  logic              take_tog;
  logic              load;
  logic [CHAR_W-1:0] load_word;
  logic              run_next;
  logic              char_last;

  stx_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  stx_hold_buf #(.CHAR_W(CHAR_W)) u_buf (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .wr_stb    (wr_stb),
    .wr_data   (wr_data),
    .take_tog  (take_tog),
    .full      (full),
    .hold_data (hold_data)
  );

  stx_sequencer #(.CHAR_W(CHAR_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .tx_en     (tx_en),
    .two_sync  (two_sync),
    .sync1     (sync1),
    .sync2     (sync2),
    .full      (full),
    .hold_data (hold_data),
    .char_last (char_last),
    .load      (load),
    .load_word (load_word),
    .run_next  (run_next),
    .take_tog  (take_tog),
    .tx_empty  (tx_empty)
  );

  stx_shifter #(.CHAR_W(CHAR_W)) u_shift (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .load      (load),
    .load_word (load_word),
    .run_next  (run_next),
    .txd       (txd),
    .char_last (char_last)
  );

  assign buf_ready = ~full;

  // R9: an empty transmitter always has room for the next byte.
  a_r9_empty_implies_ready : assert property (
    @(posedge clk) disable iff (!rst_sync_n)
    tx_empty |-> buf_ready
  );

endmodule

// File: tb/test_sync_tx_filler.sv
`timescale 1ns/1ps
module test_sync_tx_filler;

  localparam int W = 8;
  localparam logic [W-1:0] S1 = 8'h96;
  localparam logic [W-1:0] S2 = 8'h3B;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         tx_en;
  logic         two_sync;
  logic [W-1:0] sync1;
  logic [W-1:0] sync2;
  logic         wr_stb;
  logic [W-1:0] wr_data;
  logic         txd;
  logic         buf_ready;
  logic         tx_empty;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  sync_tx_filler #(.CHAR_W(W)) i_sync_tx_filler (
    .clk       (clk),
    .rst_n     (rst_n),
    .tx_en     (tx_en),
    .two_sync  (two_sync),
    .sync1     (sync1),
    .sync2     (sync2),
    .wr_stb    (wr_stb),
    .wr_data   (wr_data),
    .txd       (txd),
    .buf_ready (buf_ready),
    .tx_empty  (tx_empty)
  );

  task automatic chk(input string tag, input int slot, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s slot %0d: actual %b expected %b", tag, slot, act, exp);
    end
  endtask

  // First slot at which a write seen at slot s may be sent.
  function automatic int data_slot(input int s, input bit two);
    int lead;
    lead = two ? 2 * W : W;
    if (s <= lead) return lead;
    return lead + ((s - lead + lead - 1) / lead) * lead;
  endfunction

  task automatic do_reset();
    tx_en   = 1'b0;
    wr_stb  = 1'b0;
    wr_data = '0;
    rst_n   = 1'b0;
    repeat (2) @(negedge clk);
    #2;
    chk("R1 txd", -1, txd, 1'b1);
    chk("R1 buf_ready", -1, buf_ready, 1'b1);
    chk("R1 tx_empty", -1, tx_empty, 1'b1);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #2;
    chk("R1 txd", -1, txd, 1'b1);
    chk("R1 buf_ready", -1, buf_ready, 1'b1);
    chk("R1 tx_empty", -1, tx_empty, 1'b1);
  endtask

  // s: slot at which the write is seen (-1 none); s2: second write slot (-1 none);
  // drop: iteration at which tx_en is released (-1 never).
  task automatic run_case(input bit two, input int s, input logic [W-1:0] dat,
                          input int s2, input logic [W-1:0] dat2,
                          input int drop, input int n);
    int d;
    int stop_slot;
    do_reset();
    two_sync = two;
    d = (s >= 0) ? data_slot(s, two) : 1 << 20;
    stop_slot = (drop >= 0) ? ((drop + W) / W) * W : 1 << 20;
    @(negedge clk);
    #2;
    tx_en = 1'b1;
    if (s == 0) begin
      wr_stb  = 1'b1;
      wr_data = dat;
    end
    for (int i = 0; i < n; i++) begin
      logic  e_txd;
      logic  e_rdy;
      logic  e_emp;
      logic  seen;
      string tag;
      @(negedge clk);
      #2;
      if (i >= stop_slot) begin
        e_txd = 1'b1;
        tag   = "R12";
      end else if (i >= d && i < d + W) begin
        e_txd = dat[i - d];
        tag   = "R5 R8";
      end else begin
        int seg;
        int rel;
        logic [W-1:0] b;
        seg = (i < d) ? 0 : d + W;
        rel = (i - seg) / W;
        b   = (two && (rel % 2 == 1)) ? S2 : S1;
        e_txd = b[(i - seg) % W];
        if (i < (two ? 2 * W : W) && seg == 0) tag = "R4";
        else tag = two ? "R7" : "R6";
      end
      e_rdy = !(s >= 0 && i >= s && i < d);
      e_emp = !(s >= 0 && i >= s && i < d + W);
      chk(tag, i, txd, e_txd);
      chk("R10 buf_ready", i, buf_ready, e_rdy);
      chk("R9 tx_empty", i, tx_empty, e_emp);
      seen = txd;
      wr_stb = 1'b0;
      if (i == s - 1) begin
        wr_stb  = 1'b1;
        wr_data = dat;
      end
      if (i == s2 - 1) begin
        wr_stb  = 1'b1;
        wr_data = dat2;
      end
      if (i == drop) tx_en = 1'b0;
      @(posedge clk);
      #2;
      chk("R3 rising edge hold", i, txd, seen);
    end
    wr_stb = 1'b0;
    tx_en  = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual still running, expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    sync1    = S1;
    sync2    = S2;
    two_sync = 1'b0;
    do_reset();

    // R2: loaded register but disabled line stays at mark.
    @(negedge clk);
    #2;
    wr_stb  = 1'b1;
    wr_data = 8'hC3;
    @(negedge clk);
    #2;
    wr_stb = 1'b0;
    for (int k = 0; k < 3 * W; k++) begin
      @(negedge clk);
      #2;
      chk("R2 txd idle", k, txd, 1'b0 | 1'b1);
      chk("R2 buf_ready held", k, buf_ready, 1'b0);
      chk("R2 tx_empty held", k, tx_empty, 1'b0);
    end

    // Sweep the write slot in both fill modes (R4 R5 R6 R7 R8 R9 R10).
    for (int m = 0; m < 2; m++) begin
      for (int s = 0; s <= (m ? 4 * W + 3 : 2 * W + 3); s++) begin
        logic [W-1:0] dv;
        dv = W'(8'h5A ^ (s * 37) ^ (m * 8'hF0));
        run_case(bit'(m), s, dv, -1, '0, -1, data_slot(s, bit'(m)) + 4 * W);
      end
    end

    // No writes at all: pure fill in both modes (R6 R7).
    run_case(1'b0, -1, '0, -1, '0, -1, 5 * W);
    run_case(1'b1, -1, '0, -1, '0, -1, 6 * W);

    // R11: second write while full is dropped; first byte is sent once.
    run_case(1'b1, 3, 8'hA1, 4, 8'h7E, -1, 7 * W);
    run_case(1'b0, 2, 8'h4D, 5, 8'hE2, -1, 5 * W);

    // R12: disable mid-character finishes it, then mark.
    run_case(1'b0, -1, '0, -1, '0, 11, 4 * W);
    run_case(1'b1, -1, '0, -1, '0, 20, 5 * W);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule